// File: doc/BRIEF.md
# Snooping Write-Through Data Cache

This block is a small direct-mapped data cache that sits between one processor and a shared memory bus. Each line holds one word. A processor read that finds a valid line with a matching tag completes in the same cycle. A read that misses fetches the word over the bus and fills the line. Every processor write goes out to memory over the bus. The cached copy is updated only when the write address is already resident, so a write miss does not allocate a line.

Other masters on the same bus write memory directly. The block watches those writes through a snoop input. When an observed write targets an address that the cache holds, the block clears that line's valid bit. The next processor access to that address then misses and fetches the current value from memory. The processor holds its request until the block asserts ready. The bus side uses a request/acknowledge handshake in which the acknowledge lasts one cycle.

Top module: `snc_cache`

## Requirements
- R1: A processor read whose line is valid with a matching tag asserts `cpu_ready` in the same cycle as the request, with the cached word on `cpu_rdata`, and issues no bus transaction.
- R2: A processor read that misses raises `bus_req` with `bus_we`=0 and `bus_addr` equal to the request address in the next cycle. In the cycle of `bus_ack`, `cpu_ready` is asserted with `cpu_rdata` equal to `bus_rdata`, and the line is filled, so a repeated read hits.
- R3: Every processor write raises `bus_req` with `bus_we`=1, carrying the request address and data in the next cycle, and asserts `cpu_ready` in the cycle of `bus_ack`.
- R4: A processor write to a resident address also updates the cached word, so a following read hits and returns the new data.
- R5: A processor write to a non-resident address does not allocate a line, so a following read of that address misses.
- R6: A snoop write (`snp_valid`=1) whose address matches a valid resident line invalidates that line, so the next read misses and returns the value now in memory.
- R7: A snoop write to the same line index but a different tag leaves the resident line valid.
- R8: When a snoop write and a local line access (read hit, fill or write-hit update) fall on the same line index in the same cycle, the invalidation wins. A read is treated as a miss, and a line filled or updated in that cycle ends invalid.
- R9: After reset `cpu_ready` and `bus_req` are low and every line is invalid, so the first read of any address misses.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_we` and `bus_wdata` stay unchanged into the next cycle.
- R11: `cpu_ready` is asserted only while `cpu_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits index, rest tag |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access complete |
| bus_req | output | 1 | Bus transaction request, held until `bus_ack` |
| bus_we | output | 1 | 1 = memory write, 0 = memory read |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Memory read data, valid with `bus_ack` |
| bus_ack | input | 1 | One-cycle transaction acknowledge |
| snp_valid | input | 1 | Another master writes memory this cycle |
| snp_addr | input | ADDR_W | Address of that external write |

## Verification
The hardest situation to reach is a snoop write that lands in exactly the cycle in which the cache fills a line or updates a line after a write. That cycle is set by the memory's acknowledge, not by the processor. The bench gives its memory responder a one-shot arming flag. When the flag is set, the responder pulses the snoop input on the same cycle as its acknowledge, and it updates its own memory copy as the external master would. A read hit that collides with a snoop is easier to reach, because the request and the snoop can be driven on the same edge. Random traffic over 64 addresses that share 16 lines then checks every read against memory and against a bench model that predicts hit or miss.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_FILL  = 2'd1,
    CS_WRITE = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/snc_tag_store.sv
module snc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag,
  output logic             snp_match,
  output logic             snp_clash
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] kill;

  assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign snp_match = snp_en && valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign snp_clash = snp_en && (snp_idx == lk_idx);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign kill[g] = snp_en && (snp_idx == IDX_W'(g)) &&
                     ((valid_q[g] && tag_q[g] == snp_tag) ||
                      (wr_en && lk_idx == IDX_W'(g)));

    always_ff @(posedge clk) begin
      if (!rst_n)                               valid_q[g] <= 1'b0;
      else if (kill[g])                         valid_q[g] <= 1'b0;
      else if (wr_en && lk_idx == IDX_W'(g))    valid_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en && lk_idx == IDX_W'(g)) tag_q[g] <= wr_tag;
    end
  end

  AST_SNOOP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    snp_match |=> !valid_q[$past(snp_idx)]); // R6
  AST_CLASH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && snp_clash) |=> !valid_q[$past(lk_idx)]); // R8
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !snp_clash) |=> valid_q[$past(lk_idx)]); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> valid_q == '0); // R9
endmodule

// File: rtl/snc_data_store.sv
module snc_data_store #(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] word_q [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) word_q[idx] <= wr_data;
  end

  assign rd_data = word_q[idx];
endmodule

// File: rtl/snc_ctrl.sv
module snc_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  input  logic              lk_hit,
  input  logic              snp_clash,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              line_wr,
  output logic              in_idle,
  output logic              in_fill
);
  ctl_state_t state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              read_hit;
  logic              accept;

  assign in_idle   = (state_q == CS_IDLE);
  assign in_fill   = (state_q == CS_FILL);
  assign read_hit  = in_idle && cpu_req && !cpu_we && lk_hit && !snp_clash;
  assign accept    = in_idle && cpu_req && !read_hit;
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;

  always_comb begin
    state_d   = state_q;
    cpu_ready = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    line_wr   = 1'b0;
    unique case (state_q)
      CS_IDLE: begin
        if (read_hit)    cpu_ready = 1'b1;
        else if (accept) state_d = cpu_we ? CS_WRITE : CS_FILL;
      end
      CS_FILL: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          cpu_ready = 1'b1;
          line_wr   = 1'b1;
          state_d   = CS_IDLE;
        end
      end
      CS_WRITE: begin
        bus_req = 1'b1;
        bus_we  = 1'b1;
        if (bus_ack) begin
          cpu_ready = 1'b1;
          line_wr   = lk_hit;
          state_d   = CS_IDLE;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= CS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
    end
  end

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req); // R11
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R10
  AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_req && !cpu_we && !cpu_ready) |=> (bus_req && !bus_we && bus_addr == $past(cpu_addr))); // R2
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_req && cpu_we) |=> (bus_req && bus_we && bus_wdata == $past(cpu_wdata))); // R3
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_ready) |=> !bus_req); // R1
endmodule

// File: rtl/snc_cache.sv
module snc_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  function automatic logic [IDX_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit, snp_match, snp_clash;
  logic              line_wr, in_idle, in_fill;
  logic [DATA_W-1:0] line_data, fill_data;

  assign lk_addr   = in_idle ? cpu_addr : bus_addr;
  assign fill_data = in_fill ? bus_rdata : bus_wdata;
  assign cpu_rdata = in_fill ? bus_rdata : line_data;

  snc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (line_of(lk_addr)),
    .lk_tag    (tag_of(lk_addr)),
    .lk_hit    (lk_hit),
    .wr_en     (line_wr),
    .wr_tag    (tag_of(lk_addr)),
    .snp_en    (snp_valid),
    .snp_idx   (line_of(snp_addr)),
    .snp_tag   (tag_of(snp_addr)),
    .snp_match (snp_match),
    .snp_clash (snp_clash)
  );

  snc_data_store #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (line_wr),
    .idx     (line_of(lk_addr)),
    .wr_data (fill_data),
    .rd_data (line_data)
  );

  snc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_ready (cpu_ready),
    .lk_hit    (lk_hit),
    .snp_clash (snp_clash),
    .bus_ack   (bus_ack),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .line_wr   (line_wr),
    .in_idle   (in_idle),
    .in_fill   (in_fill)
  );

  AST_CLASH_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && cpu_req && !cpu_we && snp_clash) |-> !cpu_ready); // R8
  AST_SNOOP_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_match && !(cpu_req && in_idle)) |=> !(lk_hit && lk_addr == $past(snp_addr))); // R6
endmodule

// File: tb/snc_cache_tb.sv
`timescale 1ns/1ps
module snc_cache_tb;
  localparam int AW = 16, DW = 32, NL = 16, MEMN = 256;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, bus_wdata;
  logic [DW-1:0] bus_rdata = '0;
  logic cpu_ready, bus_req, bus_we, bus_ack = 0;
  logic [AW-1:0] bus_addr, snp_addr;
  logic snp_t = 0, snp_r = 0, snp_valid;
  logic [AW-1:0] snp_a_t = '0, snp_a_r = '0;

  assign snp_valid = snp_t | snp_r;
  assign snp_addr  = snp_r ? snp_a_r : snp_a_t;

  always #10 clk = ~clk;

  snc_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .snp_valid(snp_valid), .snp_addr(snp_addr));

  logic [DW-1:0] mem [MEMN];
  int rd_n = 0, wr_n = 0;
  int total = 0, bad = 0;
  bit arm = 0;
  logic [AW-1:0] arm_addr;
  logic [DW-1:0] arm_data;
  bit sh_v [NL];
  int sh_t [NL];

  function automatic int f_idx(input logic [AW-1:0] a); return int'(a) % NL; endfunction
  function automatic int f_tag(input logic [AW-1:0] a); return int'(a) / NL; endfunction
  function automatic bit f_hit(input logic [AW-1:0] a);
    return sh_v[f_idx(a)] && sh_t[f_idx(a)] == f_tag(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder on the bus side, with optional snoop on the ack cycle
  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      bus_ack = 0;
      snp_r = 0;
      if (bus_req && rst_n) begin
        if (wait_c == 0) begin
          bus_ack = 1;
          if (bus_we) begin mem[bus_addr[7:0]] = bus_wdata; wr_n++; end
          else begin bus_rdata = mem[bus_addr[7:0]]; rd_n++; end
          if (arm) begin
            snp_r = 1; snp_a_r = arm_addr; mem[arm_addr[7:0]] = arm_data; arm = 0;
          end
          wait_c = $urandom_range(0, 2);
        end else wait_c--;
      end
    end
  end

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit with_snp, input logic [AW-1:0] sa,
                        output logic [DW-1:0] rd, output bit used_bus, output bit first_ready);
    int r0, w0;
    r0 = rd_n; w0 = wr_n;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (with_snp) begin snp_t = 1; snp_a_t = sa; mem[sa[7:0]] = d ^ 32'h5A5A_0000; end
    #2;
    first_ready = cpu_ready;
    while (!cpu_ready) begin
      @(negedge clk);
      snp_t = 0;
      #2;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 0; snp_t = 0;
    used_bus = (rd_n != r0) || (wr_n != w0);
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_t = 1; snp_a_t = a; mem[a[7:0]] = d;
    if (f_hit(a)) sh_v[f_idx(a)] = 0;
    @(negedge clk);
    snp_t = 0;
  endtask

  // read with model prediction and checks
  task automatic do_read(input logic [AW-1:0] a, input string req);
    logic [DW-1:0] rd; bit ub, fr; bit ph;
    ph = f_hit(a);
    access(0, a, '0, 0, '0, rd, ub, fr);
    chk(rd == mem[a[7:0]], req, rd, mem[a[7:0]]);
    chk(ub == !ph, req, 32'(ub), 32'(!ph));
    sh_v[f_idx(a)] = 1; sh_t[f_idx(a)] = f_tag(a);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    logic [DW-1:0] rd; bit ub, fr;
    access(1, a, d, 0, '0, rd, ub, fr);
    chk(ub && mem[a[7:0]] == d, req, mem[a[7:0]], d);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'(wd), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd; bit ub, fr;
    void'($urandom(32'h0000_C0DE));
    for (int i = 0; i < MEMN; i++) mem[i] = (i * 32'h0101_0101) ^ 32'hA500_0000;
    for (int i = 0; i < NL; i++) begin sh_v[i] = 0; sh_t[i] = 0; end
    repeat (3) @(posedge clk);
    #2;
    chk(cpu_ready == 0 && bus_req == 0, "R9 reset outputs", {cpu_ready, bus_req}, 0);
    @(negedge clk); rst_n = 1;

    // R9 / R2: first read misses and fills
    do_read(16'h0005, "R9 R2 first read miss");
    // R1: repeat read hits with no bus traffic
    access(0, 16'h0005, '0, 0, '0, rd, ub, fr);
    chk(fr && !ub && rd == mem[5], "R1 read hit same cycle", rd, mem[5]);
    // R3 / R4: write hit goes to memory and updates the line
    do_write(16'h0005, 32'hDEAD_0005, "R3 write through");
    do_read(16'h0005, "R4 write hit updates line");
    // R5: write miss does not allocate
    do_write(16'h0026, 32'hBEEF_0026, "R3 write miss through");
    do_read(16'h0026, "R5 no write allocate");
    // R6: matching snoop invalidates, refetch sees new memory value
    snoop(16'h0005, 32'h1111_2222);
    do_read(16'h0005, "R6 snoop invalidate");
    // R7: same index, other tag, no invalidation
    do_read(16'h0017, "R7 fill");
    snoop(16'h0027, 32'h3333_4444);
    do_read(16'h0017, "R7 other tag keeps line");
    // R8: snoop on the fill acknowledge cycle
    arm_addr = 16'h0008; arm_data = 32'h7777_0008; arm = 1;
    access(0, 16'h0008, '0, 0, '0, rd, ub, fr);
    sh_v[8] = 0;
    chk(ub, "R8 fill clash read used bus", 32'(ub), 1);
    do_read(16'h0008, "R8 fill clash line invalid");
    // R8: snoop on a write-hit update cycle (same index, other tag)
    do_read(16'h0009, "R8 setup");
    arm_addr = 16'h0019; arm_data = 32'h9999_0019; arm = 1;
    do_write(16'h0009, 32'hAAAA_0009, "R8 write clash");
    sh_v[9] = 0;
    do_read(16'h0009, "R8 write clash line invalid");
    // R8: snoop in the same cycle as a read hit
    do_read(16'h000A, "R8 setup hit");
    access(0, 16'h000A, '0, 1, 16'h001A, rd, ub, fr);
    chk(!fr && ub, "R8 read hit blocked by clash", 32'(fr), 0);
    chk(rd == mem[10], "R8 read after clash data", rd, mem[10]);

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a;
      int op;
      a = AW'($urandom_range(0, 63));
      op = $urandom_range(0, 9);
      if (op < 5) do_read(a, "R1 R2 random read");
      else if (op < 8) begin
        logic [DW-1:0] d;
        d = $urandom();
        do_write(a, d, "R3 random write");
        if (!f_hit(a)) ; // R5: no allocate on miss
      end else snoop(a, $urandom());
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule